// File: doc/BRIEF.md
# Packed Default Attribute Register Loader

This block holds a small table of fall-back vertex input vectors. Each entry carries four 24-bit floating-point components (x, y, z, w) that a vertex fetch unit uses for any input attribute that has no memory stream behind it. The table is filled through a register write bus. A 96-bit vector is too wide for one 32-bit register write, so software packs the four 24-bit components into three consecutive 32-bit writes.

Software first writes a slot number to the index register. It then writes the packed words to any of the three data registers. The block counts the data writes. On the third one it unpacks the stream, stores the vector in the slot the index selects, and moves the index on to the next slot. A whole table can therefore be loaded with one index write followed by a run of data writes. If a vector is committed while the index points past the last slot, the store is dropped and a sticky error flag is raised. The fetch side reads any slot at any time through a combinational read port.

Top module: `dflt_attr_loader`

## Requirements
- R1: After reset, every slot reads as all zero, the error flag is low, and both the slot index and the partial-write count are zero.
- R2: When `wr_en` is high and `wr_addr` is none of 0x232, 0x233, 0x234 or 0x235, the write has no effect on the slots, the error flag, the index or the partial-write count.
- R3: A write to 0x233, 0x234 or 0x235 appends the data word to the partial vector. Which of the three addresses is used makes no difference. The third data write commits the vector, and the count then returns to zero.
- R4: At commit, with the words taken in arrival order as word0, word1, word2: w = word0[31:8], z = {word0[7:0], word1[31:16]}, y = {word1[15:0], word2[31:24]} and x = word2[23:0]. The read port presents {rd_x, rd_y, rd_z, rd_w}.
- R5: A commit stores the vector into the slot given by the index register. When that index is below 16, the index then increases by one, so successive vectors fill successive slots.
- R6: A commit made while the index is 16 or greater leaves every slot unchanged, leaves the index unchanged and sets the error flag.
- R7: Once set, the error flag stays high through any traffic until a write to the index register (0x232) clears it.
- R8: A write to 0x232 loads the index from `wr_data` and discards any partially collected words, so the next data write is taken as word0.
- R9: `rd_x`, `rd_y`, `rd_z` and `rd_w` show the slot selected by `rd_slot` in the same cycle, and a stored vector is visible from the cycle after its commit edge.
- R10: While `wr_en` is low, address and data values have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_addr | input | 10 | Register address of the write |
| wr_data | input | 32 | Write data |
| rd_slot | input | 4 | Slot selected for the fetch read port |
| rd_x | output | 24 | Component x of the selected slot |
| rd_y | output | 24 | Component y of the selected slot |
| rd_z | output | 24 | Component z of the selected slot |
| rd_w | output | 24 | Component w of the selected slot |
| err_flag | output | 1 | Sticky flag for a commit made with the index out of range |

## Verification
Every registered result is due one clock edge after the write that causes it. Commits, index updates and the error flag all settle on the same rising edge that samples the third data word or the index write. The bench drives each write on a falling edge, lets exactly one rising edge pass, drops the strobe, and only then updates its model and compares. The read port is combinational, so the bench changes `rd_slot` while the bus is idle and samples one time unit later. Idle edges alter nothing, so a sweep over all slots may span several clock edges without moving the point at which a result is due.

// File: rtl/dal_pkg.sv
package dal_pkg;

    // Packed words needed to carry one four-component vector.
    localparam int WORDS_PER_VEC = 3;
    localparam int COMPS_PER_VEC = 4;

    // Kind of register access decoded from the bus.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_INDEX = 2'd1,
        ACC_DATA  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/dal_decode.sv
module dal_decode
    import dal_pkg::*;
#(
    parameter int              ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 10'h232
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output acc_kind_e         kind
);
    logic [WORDS_PER_VEC-1:0] hit_data;

    // One comparator per data register, placed right after the index register.
    for (genvar g = 0; g < WORDS_PER_VEC; g++) begin : g_data_hit
        assign hit_data[g] = (wr_addr == IDX_ADDR + ADDR_W'(g + 1));
    end

    always_comb begin
        kind = ACC_NONE;
        if (wr_en) begin
            if (wr_addr == IDX_ADDR) begin
                kind = ACC_INDEX;
            end else if (|hit_data) begin
                kind = ACC_DATA;
            end
        end
    end
endmodule

// File: rtl/dal_unpack.sv
module dal_unpack
    import dal_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int COMP_W = 24,
    localparam int VEC_W = COMPS_PER_VEC * COMP_W
) (
    input  logic [DATA_W-1:0] word0,
    input  logic [DATA_W-1:0] word1,
    input  logic [DATA_W-1:0] word2,
    output logic [VEC_W-1:0]  vec    // x in the low component, w in the high one
);
    localparam int STREAM_W = WORDS_PER_VEC * DATA_W;

    logic [STREAM_W-1:0] stream;

    // The first word arrives first and holds the most significant bits.
    assign stream = {word0, word1, word2};

    // Component k is read from the k-th COMP_W slice counted from the stream's
    // last bit, so the last arriving bits form x and the first form w.
    for (genvar k = 0; k < COMPS_PER_VEC; k++) begin : g_comp
        assign vec[k*COMP_W +: COMP_W] = stream[k*COMP_W +: COMP_W];
    end

    initial begin
        if (STREAM_W != VEC_W) begin
            $error("dal_unpack: three data words must carry exactly four components");
        end
    end
endmodule

// File: rtl/dal_slots.sv
module dal_slots #(
    parameter int NUM_SLOTS = 16,
    parameter int VEC_W     = 96,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  logic [VEC_W-1:0]  wdata,
    input  logic [SLOT_W-1:0] raddr,
    output logic [VEC_W-1:0]  rdata
);
    logic [NUM_SLOTS-1:0][VEC_W-1:0] mem_d, mem_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_comb begin
            mem_d[s] = mem_q[s];
            if (we && (waddr == SLOT_W'(s))) begin
                mem_d[s] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[s] <= '0;
            end else begin
                mem_q[s] <= mem_d[s];
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dflt_attr_loader.sv
module dflt_attr_loader
    import dal_pkg::*;
#(
    parameter int                ADDR_W    = 10,
    parameter int                DATA_W    = 32,
    parameter int                COMP_W    = 24,
    parameter int                NUM_SLOTS = 16,
    parameter logic [ADDR_W-1:0] IDX_ADDR  = 10'h232,
    localparam int               SLOT_W    = $clog2(NUM_SLOTS),
    localparam int               VEC_W     = COMPS_PER_VEC * COMP_W,
    localparam int               CNT_W     = $clog2(WORDS_PER_VEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [COMP_W-1:0] rd_x,
    output logic [COMP_W-1:0] rd_y,
    output logic [COMP_W-1:0] rd_z,
    output logic [COMP_W-1:0] rd_w,
    output logic              err_flag
);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORDS_PER_VEC - 1);

    typedef struct packed {
        logic [CNT_W-1:0]                          cnt;
        logic [DATA_W-1:0]                         idx;
        logic                                      err;
        logic [WORDS_PER_VEC-2:0][DATA_W-1:0]      held;
    } ctl_t;

    ctl_t              st_d, st_q;
    acc_kind_e         kind;
    logic              commit;
    logic              store_ok;
    logic              idx_in_range;
    logic [VEC_W-1:0]  vec_new;
    logic [VEC_W-1:0]  vec_rd;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] idx_q;

    dal_decode #(
        .ADDR_W  (ADDR_W),
        .IDX_ADDR(IDX_ADDR)
    ) u_decode (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .kind   (kind)
    );

    dal_unpack #(
        .DATA_W(DATA_W),
        .COMP_W(COMP_W)
    ) u_unpack (
        .word0(st_q.held[0]),
        .word1(st_q.held[1]),
        .word2(wr_data),
        .vec  (vec_new)
    );

    assign idx_in_range = (st_q.idx < DATA_W'(NUM_SLOTS));

    always_comb begin
        st_d     = st_q;
        commit   = 1'b0;
        store_ok = 1'b0;
        unique case (kind)
            ACC_INDEX: begin
                st_d.idx = wr_data;
                st_d.cnt = '0;
                st_d.err = 1'b0;
            end
            ACC_DATA: begin
                if (st_q.cnt == LAST_WORD) begin
                    commit   = 1'b1;
                    st_d.cnt = '0;
                    if (idx_in_range) begin
                        store_ok = 1'b1;
                        st_d.idx = st_q.idx + DATA_W'(1);
                    end else begin
                        st_d.err = 1'b1;
                    end
                end else begin
                    st_d.held[st_q.cnt[0]] = wr_data;
                    st_d.cnt               = st_q.cnt + CNT_W'(1);
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dal_slots #(
        .NUM_SLOTS(NUM_SLOTS),
        .VEC_W    (VEC_W)
    ) u_slots (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (store_ok),
        .waddr(st_q.idx[SLOT_W-1:0]),
        .wdata(vec_new),
        .raddr(rd_slot),
        .rdata(vec_rd)
    );

    assign rd_x     = vec_rd[0*COMP_W +: COMP_W];
    assign rd_y     = vec_rd[1*COMP_W +: COMP_W];
    assign rd_z     = vec_rd[2*COMP_W +: COMP_W];
    assign rd_w     = vec_rd[3*COMP_W +: COMP_W];
    assign err_flag = st_q.err;
    assign cnt_q    = st_q.cnt;
    assign idx_q    = st_q.idx;

    logic unused_commit;
    assign unused_commit = commit;
endmodule

// File: rtl/dal_checker.sv
module dal_checker #(
    parameter int                ADDR_W    = 10,
    parameter int                DATA_W    = 32,
    parameter int                NUM_SLOTS = 16,
    parameter logic [ADDR_W-1:0] IDX_ADDR  = 10'h232,
    parameter int                CNT_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              err_flag,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [DATA_W-1:0] idx_q
);
    logic idx_wr;
    logic data_wr;

    assign idx_wr  = wr_en && (wr_addr == IDX_ADDR);
    assign data_wr = wr_en && (wr_addr > IDX_ADDR) && (wr_addr <= IDX_ADDR + ADDR_W'(3));

    // R3: the partial count never passes the last word
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(2));

    // R3: third data word returns the count to zero
    a_r3_cnt_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && cnt_q == CNT_W'(2)) |=> (cnt_q == '0));

    // R5: an in-range commit advances the index by one
    a_r5_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && cnt_q == CNT_W'(2) && idx_q < DATA_W'(NUM_SLOTS))
        |=> (idx_q == $past(idx_q) + DATA_W'(1)));

    // R6: an out-of-range commit raises the flag and holds the index
    a_r6_err_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && cnt_q == CNT_W'(2) && idx_q >= DATA_W'(NUM_SLOTS))
        |=> (err_flag && $stable(idx_q)));

    // R7: the flag is sticky until an index write
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !idx_wr) |=> err_flag);

    // R8: an index write discards partial words and clears the flag
    a_r8_idx_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (cnt_q == '0 && !err_flag));

    // R10: an idle bus leaves the control state alone
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cnt_q) && $stable(idx_q) && $stable(err_flag)));
endmodule

bind dflt_attr_loader dal_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_SLOTS(NUM_SLOTS),
    .IDX_ADDR (IDX_ADDR),
    .CNT_W    (CNT_W)
) u_dal_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .err_flag(err_flag),
    .cnt_q   (cnt_q),
    .idx_q   (idx_q)
);

// File: tb/dflt_attr_loader_bench.sv
module dflt_attr_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] A_IDX = 10'h232;
    localparam logic [9:0] A_D0  = 10'h233;
    localparam logic [9:0] A_D1  = 10'h234;
    localparam logic [9:0] A_D2  = 10'h235;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_slot = '0;
    logic [23:0] rd_x, rd_y, rd_z, rd_w;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [95:0] m_slot [16];
    logic [31:0] m_idx;
    int          m_cnt;
    logic [31:0] m_buf [3];
    logic        m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    dflt_attr_loader u_dflt_attr_loader (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_slot(rd_slot), .rd_x(rd_x), .rd_y(rd_y),
        .rd_z(rd_z), .rd_w(rd_w), .err_flag(err_flag)
    );

    // Expected vector {x,y,z,w} from three packed words (R4)
    function automatic logic [95:0] exp_vec(logic [31:0] a, logic [31:0] b, logic [31:0] c);
        logic [23:0] ex, ey, ez, ew;
        ew = a[31:8];
        ez = {a[7:0], b[31:16]};
        ey = {b[15:0], c[31:24]};
        ex = c[23:0];
        return {ex, ey, ez, ew};
    endfunction

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [9:0] a, input logic [31:0] d);
        if (a == A_IDX) begin
            m_idx = d; m_cnt = 0; m_err = 1'b0;
        end else if (a == A_D0 || a == A_D1 || a == A_D2) begin
            m_buf[m_cnt] = d;
            if (m_cnt == 2) begin
                m_cnt = 0;
                if (m_idx < 32'd16) begin
                    m_slot[m_idx[3:0]] = exp_vec(m_buf[0], m_buf[1], m_buf[2]);
                    m_idx = m_idx + 1;
                end else begin
                    m_err = 1'b1;
                end
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic read_slot(input logic [3:0] s, input string tag);
        rd_slot = s;
        #1;
        chk(tag, {rd_x, rd_y, rd_z, rd_w}, m_slot[s]);
    endtask

    task automatic check_all(input string tag);
        for (int s = 0; s < 16; s++) read_slot(4'(s), tag);
    endtask

    task automatic check_err(input string tag);
        chk(tag, 96'(err_flag), 96'(m_err));
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int s = 0; s < 16; s++) m_slot[s] = '0;
        m_idx = '0; m_cnt = 0; m_err = 1'b0;
        for (int i = 0; i < 3; i++) m_buf[i] = '0;
        void'($urandom(32'h1234_5678));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check_all("R1 reset slot");
        check_err("R1 reset err");

        // R4/R5: first vector into slot 0 at fixed constants (no index write: reset index 0)
        wr(A_D0, 32'hAABBCCDD);
        wr(A_D1, 32'h11223344);
        read_slot(4'd0, "R3 no commit before third word");
        wr(A_D2, 32'h55667788);
        rd_slot = 4'd0; #1;
        chk("R4 unpack x", 96'(rd_x), 96'(24'h667788));
        chk("R4 unpack y", 96'(rd_y), 96'(24'h334455));
        chk("R4 unpack z", 96'(rd_z), 96'(24'hDD1122));
        chk("R4 unpack w", 96'(rd_w), 96'(24'hAABBCC));
        check_all("R9 read all after first commit");

        // R3/R5: same data address three times lands in slot 1
        wr(A_D1, 32'h01020304);
        wr(A_D1, 32'h05060708);
        wr(A_D1, 32'h090A0B0C);
        read_slot(4'd1, "R3 R5 same address next slot");

        // R2: stray addresses with strobe high
        wr(10'h231, 32'hFFFFFFFF);
        wr(10'h236, 32'hFFFFFFFF);
        wr(10'h000, 32'hFFFFFFFF);
        wr(A_D2, 32'hCAFEF00D);
        wr(A_D0, 32'h0BADBEEF);
        wr(A_D1, 32'h12345678);
        check_all("R2 stray writes ignored");

        // R10: strobe low with a data address
        @(negedge clk);
        wr_en = 1'b0; wr_addr = A_D0; wr_data = 32'hDEADDEAD;
        repeat (3) @(posedge clk);
        #1;
        wr(A_D0, 32'h11111111);
        wr(A_D0, 32'h22222222);
        wr(A_D0, 32'h33333333);
        check_all("R10 idle strobe ignored");

        // R8: partial sequence discarded by index write
        wr(A_D0, 32'hEEEEEEEE);
        wr(A_D1, 32'hDDDDDDDD);
        wr(A_IDX, 32'd9);
        wr(A_D0, 32'h87654321);
        wr(A_D1, 32'h0F0F0F0F);
        wr(A_D2, 32'hF0F0F0F0);
        check_all("R8 realign after index write");

        // R6: last slot then overrun
        wr(A_IDX, 32'd15);
        wr(A_D0, 32'hA5A5A5A5);
        wr(A_D1, 32'h5A5A5A5A);
        wr(A_D2, 32'h3C3C3C3C);
        read_slot(4'd15, "R5 last slot");
        check_err("R5 no err on slot 15");
        wr(A_D0, 32'h99999999);
        wr(A_D1, 32'h88888888);
        wr(A_D2, 32'h77777777);
        check_err("R6 err on overrun");
        check_all("R6 slots unchanged");
        // Index unchanged: a fresh in-range write is needed to store again
        wr(A_D0, 32'h1); wr(A_D1, 32'h2); wr(A_D2, 32'h3);
        check_all("R6 index held past end");

        // R7: sticky through traffic, cleared by index write
        wr(10'h100, 32'h0);
        wr(A_D2, 32'h4);
        check_err("R7 err sticky");
        wr(A_IDX, 32'd200);
        check_err("R7 err cleared by index write");

        // Random phase
        for (int n = 0; n < 600; n++) begin
            int sel;
            logic [9:0]  a;
            logic [31:0] d;
            sel = int'($urandom_range(0, 9));
            d = $urandom();
            if (sel == 0) begin
                a = A_IDX;
                d = 32'($urandom_range(0, 18));
            end else if (sel == 1) begin
                a = 10'($urandom());
                if (a >= A_IDX && a <= A_D2) a = 10'h3FF;
            end else begin
                a = A_D0 + 10'($urandom_range(0, 2));
            end
            wr(a, d);
            check_err("R6 R7 random err");
            read_slot(4'($urandom_range(0, 15)), "R3 R4 R5 random slot");
        end
        check_all("R9 final sweep");

        done = 1'b1;
        finish_run();
    end
endmodule